// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns a single "supply good" comparator bit into a clean active-low system reset. The reset stays low while the supply is below its threshold. It is released only after the supply has stayed good, without a break, for a programmable number of clock cycles. The comparator bit arrives from another domain, so it is synchronized before any decision is made on it.

Once the reset has been released, short drops of the comparator bit are treated as noise. A drop is acted on only if it lasts longer than a programmable filter length. A drop that qualifies pulls the reset low for at least one full reset period, even if the supply comes back sooner. If the supply is still bad when that period ends, the reset stays low until the supply has again been good for a full period. An asynchronous power-on clear puts the block into its asserted state at any time.

Top module: `supply_reset_gen`

## Requirements
- R1: While `por_n` is low, and from power-up onward while the synchronized supply bit is low, `res_n` is 0.
- R2: While reset is held for a bad supply, `res_n` rises only after the synchronized supply bit has been 1 on N consecutive clock edges, where N is `reset_period`. Any 0 restarts the count. `supply_ok` reaches the decision logic two edges after it is driven.
- R3: After release, a low run of the synchronized supply bit lasting G edges or fewer, where G is the latched filter length, leaves `res_n` at 1.
- R4: After release, a low run that reaches G+1 edges drives `res_n` to 0 after that edge.
- R5: A qualified drop keeps `res_n` at 0 for exactly `reset_period` edges when the supply is good at the end of that time, and `res_n` then returns to 1.
- R6: If the supply is still bad when the forced period ends, `res_n` stays 0 and is released only after a fresh run of `reset_period` good edges.
- R7: A value of 0 on `reset_period` or on `glitch_len` acts as 1.
- R8: `glitch_len` is sampled only while `res_n` is 0. A change made while reset is released has no effect until the next assertion.
- R9: Driving `por_n` low forces `res_n` to 0 at once, without a clock edge, and clears all counting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Asynchronous supply comparator result, 1 = good |
| reset_period | input | 16 | Good-supply cycles needed before release, and the minimum forced hold |
| glitch_len | input | 8 | Longest drop, in cycles, that is ignored after release |
| res_n | output | 1 | System reset, active low |

## Verification
The bench targets a dip of exactly G cycles and one of G+1 cycles. A design with an off-by-one in the filter would either reset on the harmless dip or let the qualifying one through. It also drops the supply for one cycle in the middle of the release count, which catches a counter that pauses instead of restarting. It holds the supply low past the end of a forced period: a design that released on a timer alone would raise reset into a dead supply. Finally, it changes the filter length while reset is released and runs with zero lengths, which exposes live use of `glitch_len` and a zero that wraps into a huge count.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef enum logic [1:0] {
    SUP_HOLD  = 2'd0,
    SUP_RUN   = 2'd1,
    SUP_FORCE = 2'd2
  } sup_state_e;

  // a programmed length of zero behaves as a single cycle
  function automatic logic [31:0] clamp_len(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 (
  input  logic clk,
  input  logic por_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      meta_q <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/sup_period_timer.sv
module sup_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] limit,
  output logic          done
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_idx;

  assign last_idx = limit - 1'b1;
  assign done     = en && (cnt_q >= last_idx);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (en)      cnt_q <= done ? '0 : cnt_q + 1'b1;
  end

  // R2: after a clear the count starts again from zero
  assert_restart_from_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
    (clr && !en) |=> !(done && limit > 1));
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          en,
  input  logic          ok_s,
  input  logic [GW-1:0] glen,
  output logic          qualify
);
  logic [GW-1:0] low_q;

  assign qualify = en && !ok_s && (low_q == glen);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               low_q <= '0;
    else if (!en || ok_s)     low_q <= '0;
    else if (low_q != glen)   low_q <= low_q + 1'b1;
  end

  // R3: the run-length counter never passes the filter length
  assert_low_run_bounded_R3: assert property (@(posedge clk) disable iff (!por_n)
    en |-> (low_q <= glen));
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import supply_reset_pkg::*;
#(
  parameter int PW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          supply_ok,
  input  logic [PW-1:0] reset_period,
  input  logic [GW-1:0] glitch_len,
  output logic          res_n
);
  sup_state_e    state_q, state_d;
  logic          ok_s;
  logic [PW-1:0] period_eff;
  logic [GW-1:0] glen_q;
  logic          tmr_en, tmr_clr, tmr_done;
  logic          released, qualify;

  assign period_eff = PW'(clamp_len(32'(reset_period)));
  assign released   = (state_q == SUP_RUN);
  assign res_n      = released;

  sup_sync2 u_sync (
    .clk     (clk),
    .por_n   (por_n),
    .d_async (supply_ok),
    .q_sync  (ok_s)
  );

  always_comb begin
    tmr_en  = 1'b0;
    tmr_clr = 1'b0;
    unique case (state_q)
      SUP_HOLD:  begin tmr_en = ok_s; tmr_clr = !ok_s; end
      SUP_FORCE: tmr_en = 1'b1;
      default:   tmr_clr = 1'b1;
    endcase
  end

  sup_period_timer #(.PW(PW)) u_timer (
    .clk   (clk),
    .por_n (por_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .limit (period_eff),
    .done  (tmr_done)
  );

  // filter length follows the input only while reset is asserted
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         glen_q <= GW'(1);
    else if (!released) glen_q <= GW'(clamp_len(32'(glitch_len)));
  end

  sup_glitch_filter #(.GW(GW)) u_filter (
    .clk     (clk),
    .por_n   (por_n),
    .en      (released),
    .ok_s    (ok_s),
    .glen    (glen_q),
    .qualify (qualify)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUP_HOLD:  if (tmr_done) state_d = SUP_RUN;
      SUP_RUN:   if (qualify)  state_d = SUP_FORCE;
      SUP_FORCE: if (tmr_done) state_d = ok_s ? SUP_RUN : SUP_HOLD;
      default:   state_d = SUP_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= SUP_HOLD;
    else        state_q <= state_d;
  end

  // R2: a bad supply while held keeps reset low
  assert_hold_while_bad_R2: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == SUP_HOLD && !ok_s) |=> !res_n);

  // R4: a qualified drop asserts reset on the next cycle
  assert_qualified_drop_R4: assert property (@(posedge clk) disable iff (!por_n)
    qualify |=> !res_n);

  // R3: with no qualified drop a released reset stays released
  assert_stay_released_R3: assert property (@(posedge clk) disable iff (!por_n)
    (res_n && !qualify) |=> res_n);

  // R5: release only happens on a cycle where the supply was seen good
  assert_release_needs_good_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(res_n) |-> $past(ok_s));
endmodule

// File: tb/tb_supply_reset_gen.sv
module tb_supply_reset_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        supply_ok = 1'b0;
  logic [15:0] reset_period = 16'd10;
  logic [7:0]  glitch_len = 8'd3;
  logic        res_n;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R1 power-up";

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_gen dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok),
    .reset_period(reset_period), .glitch_len(glitch_len), .res_n(res_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: res_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: mode 0 waiting for good supply, 1 released, 2 forced hold
  int   m_mode = 0, good_run = 0, low_run = 0, left = 0, m_glen = 1, m_per;
  logic h1 = 1'b0, h2 = 1'b0, seen;

  always @(posedge clk) begin
    if (!por_n) begin
      m_mode = 0; good_run = 0; low_run = 0; left = 0; m_glen = 1;
      h1 = 1'b0; h2 = 1'b0;
    end else begin
      seen = h2; h2 = h1; h1 = supply_ok;
      m_per = (reset_period == 0) ? 1 : int'(reset_period);
      if (m_mode != 1) m_glen = (glitch_len == 0) ? 1 : int'(glitch_len);
      case (m_mode)
        0: if (seen) begin
             good_run++;
             if (good_run >= m_per) begin m_mode = 1; low_run = 0; end
           end else good_run = 0;
        1: if (!seen) begin
             low_run++;
             if (low_run > m_glen) begin m_mode = 2; left = m_per; end
           end else low_run = 0;
        default: begin
          left--;
          if (left <= 0) begin
            m_mode = seen ? 1 : 0; good_run = 0; low_run = 0;
          end
        end
      endcase
      sb_q.push_back('{exp: (m_mode == 1), tag: cur_tag});
    end
  end

  always @(negedge clk) begin
    item_t it;
    if (por_n && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(res_n, it.exp, it.tag);
    end
  end

  task automatic drive(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      supply_ok = v;
      cur_tag = tag;
    end
  endtask

  task automatic do_por(input logic [15:0] p, input logic [7:0] g);
    @(negedge clk);
    #2 por_n = 1'b0;
    #1 chk(res_n, 1'b0, "R9 async clear");
    reset_period = p; glitch_len = g; supply_ok = 1'b0;
    @(negedge clk);
    chk(res_n, 1'b0, "R1 held in clear");
    por_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk(res_n, 1'b0, "R1 reset state");
    @(negedge clk); por_n = 1'b1;
    drive(0, 5,  "R1 supply bad");
    drive(1, 5,  "R2 partial count");
    drive(0, 1,  "R2 restart on drop");
    drive(1, 20, "R2 release after period");
    drive(0, 3,  "R3 dip of G ignored");
    drive(1, 10, "R3 stays released");
    drive(0, 4,  "R4 dip of G+1 qualifies");
    drive(1, 20, "R5 forced period then release");
    drive(0, 3,  "R4 second qualified dip");
    drive(0, 30, "R6 sustained drop");
    drive(1, 20, "R6 fresh period after recovery");
    glitch_len = 8'd20;
    drive(0, 4,  "R8 old filter still latched");
    drive(1, 20, "R8 relatch while asserted");
    drive(0, 10, "R8 new filter ignores dip");
    drive(1, 5,  "R8 stays released");
    do_por(16'd0, 8'd0);
    drive(1, 4,  "R7 zero period acts as one");
    drive(0, 1,  "R7 one-cycle dip ignored");
    drive(1, 4,  "R7 stays released");
    drive(0, 2,  "R7 two-cycle dip qualifies");
    drive(1, 6,  "R7 one-cycle forced hold");
    do_por(16'd6, 8'd2);
    drive(1, 12, "R9 counting from clean state");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule